// File: doc/BRIEF.md
# PDM Microphone Bit-Clock Generator with Quality Modes

This block derives the bit clock for pulse-density-modulated microphones from the fast clock that runs the decimation filter. A programmable half-period count sets how many master cycles the bit clock stays low and then high. The output therefore always has a 50 % duty cycle. Each rising edge of the bit clock also produces a one-cycle capture strobe, which the downstream filter uses to sample the microphone data lines.

A 3-bit quality field selects the filter mode. Every legal mode gives four bit-clock periods per oversampling step. The oversampling ratio is sixteen minus a 4-bit field. For a master clock at a fixed multiple of the output sample rate, a combinational helper reports the bits per output sample and the half-period count that the divider should be loaded with. The two reserved quality codes stop the clock and raise an error flag until a legal code returns.

The controller is a four-state machine:

- **Idle**: the clock is parked low.
- **Low phase** and **High phase**: the two halves of each bit-clock period.
- **Fault**: entered on a reserved quality code.

The transitions are:

- **start**: Idle to Low phase.
- **rise**: Low phase to High phase, when the phase counter reaches the limit.
- **fall**: High phase to Low phase, when the phase counter reaches the limit.
- **trip**: any running state to Fault, on a reserved code.
- **recover**: Fault to Idle, on a legal code.
- **stop**: any state to Idle, when enable is low.

Top module: `pdm_bitclk_gen`

## Requirements
- R1: After reset, pdm_clk, sample_stb and cfg_err are 0 and the generator is idle.
- R2: When enable is raised with a legal quality code, the generator leaves Idle on the next edge and starts the Low phase. pdm_clk is 0 for the first D master cycles, then 1 for D cycles, and alternates like this, where D is div_val.
- R3: sample_stb is 1 for exactly one master cycle per bit-clock period. That cycle is the first cycle in which pdm_clk is 1.
- R4: A div_val of 0 behaves as 1, so pdm_clk toggles on every master cycle.
- R5: The reserved quality codes are 010 and 011. While enabled, either code moves the generator to Fault on the next edge: cfg_err becomes 1 and pdm_clk is held at 0.
- R6: When a legal code returns, the generator passes through Idle for one cycle and then restarts with a fresh Low phase.
- R7: When enable is 0, the next edge returns the generator to Idle, with pdm_clk, sample_stb and cfg_err all 0.
- R8: The legal quality codes are 000 medium, 001 high, 100 very-low-2, 101 very-low-1, 110 very-low-0 and 111 low. For each of them, bits_per_sample equals 4 times (16 minus osr_field). Reserved codes give 0.
- R9: nominal_div equals MCLK_RATIO divided by (2 × bits_per_sample), rounded down. Reserved codes give 0.
- R10: Lowering div_val below the current phase count ends the phase on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request |
| qsel | input | 3 | Quality mode code |
| osr_field | input | OSR_W (4) | Oversampling field; ratio is 2^OSR_W minus this |
| div_val | input | DIV_W (8) | Half-period length in master cycles (0 acts as 1) |
| pdm_clk | output | 1 | Microphone bit clock |
| sample_stb | output | 1 | One-cycle capture strobe at each bit-clock rise |
| cfg_err | output | 1 | Reserved quality code seen while enabled |
| bits_per_sample | output | OSR_W+3 (7) | Bit-clock periods per output sample |
| nominal_div | output | DIV_W (8) | Suggested div_val for the master-to-sample ratio |

## Verification
The bench uses the default parameters: DIV_W = 8, OSR_W = 4 and MCLK_RATIO = 1024. With these values, all 128 combinations of quality code and oversampling field can be swept, covering a suggested divider range from 8 up to 128. The half-periods tried are 0, 1, 3 and 7 master cycles. These are short enough that the waveform can be compared sample by sample over several bit-clock periods. The half-periods of 0 and 1 exercise the single-cycle phase corner, and a drop from 20 to 2 in the middle of a phase exercises the early phase end.

// File: rtl/pdm_clk_pkg.sv
package pdm_clk_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOW   = 2'd1,
        S_HIGH  = 2'd2,
        S_FAULT = 2'd3
    } pdm_state_e;

    typedef enum logic [2:0] {
        Q_MEDIUM = 3'b000,
        Q_HIGH   = 3'b001,
        Q_RSVD_A = 3'b010,
        Q_RSVD_B = 3'b011,
        Q_VLOW2  = 3'b100,
        Q_VLOW1  = 3'b101,
        Q_VLOW0  = 3'b110,
        Q_LOW    = 3'b111
    } quality_e;

    // Bit-clock periods per oversampling step = rate_mult * k_x2 / 2
    typedef struct packed {
        logic       valid;
        logic [3:0] rate_mult;
        logic [3:0] k_x2;
    } qmode_t;

endpackage

// File: rtl/pdm_quality_decode.sv
module pdm_quality_decode
    import pdm_clk_pkg::*;
(
    input  logic [2:0] qsel,
    output qmode_t     mode
);

    always_comb begin
        mode = '0;
        unique case (quality_e'(qsel))
            Q_HIGH:            mode = '{valid: 1'b1, rate_mult: 4'd8, k_x2: 4'd1};
            Q_MEDIUM, Q_VLOW0: mode = '{valid: 1'b1, rate_mult: 4'd4, k_x2: 4'd2};
            Q_LOW, Q_VLOW1:    mode = '{valid: 1'b1, rate_mult: 4'd2, k_x2: 4'd4};
            Q_VLOW2:           mode = '{valid: 1'b1, rate_mult: 4'd1, k_x2: 4'd8};
            Q_RSVD_A, Q_RSVD_B: mode = '0;
        endcase
    end

endmodule

// File: rtl/pdm_ratio_calc.sv
module pdm_ratio_calc
    import pdm_clk_pkg::*;
#(
    parameter int OSR_W      = 4,
    parameter int DIV_W      = 8,
    parameter int MCLK_RATIO = 1024,
    localparam int BPS_W     = OSR_W + 3
) (
    input  qmode_t             mode,
    input  logic [OSR_W-1:0]   osr_field,
    output logic [BPS_W-1:0]   bits_per_sample,
    output logic [DIV_W-1:0]   nominal_div
);

    localparam int OSR_SPAN = 1 << OSR_W;

    int unsigned osr;
    int unsigned bps;
    int unsigned div_full;

    always_comb begin
        osr      = OSR_SPAN - int'(osr_field);
        bps      = (osr * int'(mode.rate_mult) * int'(mode.k_x2)) / 2;
        div_full = 0;
        if (mode.valid && bps != 0) begin
            div_full = MCLK_RATIO / (2 * bps);
        end
        bits_per_sample = mode.valid ? BPS_W'(bps) : '0;
        nominal_div     = DIV_W'(div_full);
    end

endmodule

// File: rtl/pdm_bitclk_gen.sv
module pdm_bitclk_gen
    import pdm_clk_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int OSR_W      = 4,
    parameter int MCLK_RATIO = 1024,
    localparam int BPS_W     = OSR_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [2:0]       qsel,
    input  logic [OSR_W-1:0] osr_field,
    input  logic [DIV_W-1:0] div_val,
    output logic             pdm_clk,
    output logic             sample_stb,
    output logic             cfg_err,
    output logic [BPS_W-1:0] bits_per_sample,
    output logic [DIV_W-1:0] nominal_div
);

    qmode_t     mode;
    pdm_state_e state, state_nxt;
    logic [DIV_W-1:0] cnt, cnt_nxt, lim;

    pdm_quality_decode u_decode (
        .qsel (qsel),
        .mode (mode)
    );

    pdm_ratio_calc #(
        .OSR_W      (OSR_W),
        .DIV_W      (DIV_W),
        .MCLK_RATIO (MCLK_RATIO)
    ) u_ratio (
        .mode            (mode),
        .osr_field       (osr_field),
        .bits_per_sample (bits_per_sample),
        .nominal_div     (nominal_div)
    );

    // Last count of a phase; a zero divider acts as one
    assign lim = (div_val == '0) ? '0 : div_val - 1'b1;

    always_comb begin
        state_nxt = state;
        cnt_nxt   = '0;
        if (!enable) begin
            state_nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  state_nxt = mode.valid ? S_LOW : S_FAULT;
                S_LOW: begin
                    if (!mode.valid)    state_nxt = S_FAULT;
                    else if (cnt >= lim) state_nxt = S_HIGH;
                    else                cnt_nxt   = cnt + 1'b1;
                end
                S_HIGH: begin
                    if (!mode.valid)    state_nxt = S_FAULT;
                    else if (cnt >= lim) state_nxt = S_LOW;
                    else                cnt_nxt   = cnt + 1'b1;
                end
                S_FAULT: state_nxt = mode.valid ? S_IDLE : S_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        pdm_clk    = 1'b0;
        sample_stb = 1'b0;
        cfg_err    = 1'b0;
        unique case (state)
            S_IDLE, S_LOW: ;
            S_HIGH: begin
                pdm_clk    = 1'b1;
                sample_stb = (cnt == '0);
            end
            S_FAULT: cfg_err = 1'b1;
        endcase
    end

    a_r3_stb_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdm_clk) |-> sample_stb)
        else $error("a_r3_stb_at_rise");

    a_r3_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb)
        else $error("a_r3_stb_single");

    a_r5_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !mode.valid) |=> (cfg_err && !pdm_clk))
        else $error("a_r5_fault_hold");

    a_r7_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pdm_clk && !sample_stb && !cfg_err))
        else $error("a_r7_disable_quiet");

    a_r4_zero_div_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && mode.valid && $past(mode.valid)
         && div_val == '0 && $past(div_val) == '0 && pdm_clk)
        |=> !pdm_clk)
        else $error("a_r4_zero_div_toggle");

endmodule

// File: tb/test_pdm_bitclk_gen.sv
module test_pdm_bitclk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] qsel = 3'b000;
    logic [3:0] osr_field = 4'd0;
    logic [7:0] div_val = 8'd4;
    logic       pdm_clk, sample_stb, cfg_err;
    logic [6:0] bits_per_sample;
    logic [7:0] nominal_div;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pdm_bitclk_gen i_pdm_bitclk_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .enable          (enable),
        .qsel            (qsel),
        .osr_field       (osr_field),
        .div_val         (div_val),
        .pdm_clk         (pdm_clk),
        .sample_stb      (sample_stb),
        .cfg_err         (cfg_err),
        .bits_per_sample (bits_per_sample),
        .nominal_div     (nominal_div)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic go_idle();
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        check(pdm_clk == 0, "R1 pdm_clk", pdm_clk, 0);
        check(sample_stb == 0, "R1 sample_stb", sample_stb, 0);
        check(cfg_err == 0, "R1 cfg_err", cfg_err, 0);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // Sample i is taken after edge E0+i, where E0 is the first edge with enable high
    task automatic t_waveform(input int div, input string req);
        int d = (div == 0) ? 1 : div;
        go_idle();
        div_val = 8'(div);
        qsel    = 3'b001;
        enable  = 1'b1;
        for (int i = 0; i < 4 * d + 2; i++) begin
            @(negedge clk);
            begin
                bit ep = ((i / d) % 2) == 1;
                bit es = ep && (i % d == 0);
                check(pdm_clk == ep, req, pdm_clk, ep);
                check(sample_stb == es, "R3 strobe", sample_stb, es);
            end
        end
    endtask

    task automatic t_fault();
        go_idle();
        div_val = 8'd3;
        qsel    = 3'b000;
        enable  = 1'b1;
        repeat (5) @(negedge clk);
        qsel = 3'b010;
        @(negedge clk);
        check(cfg_err == 1, "R5 err on 010", cfg_err, 1);
        check(pdm_clk == 0, "R5 clk held", pdm_clk, 0);
        qsel = 3'b011;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(pdm_clk == 0 && cfg_err == 1, "R5 stay fault 011", pdm_clk, 0);
        end
        qsel = 3'b111;
        @(negedge clk);
        check(cfg_err == 0 && pdm_clk == 0, "R6 idle pass", cfg_err, 0);
        for (int k = 2; k <= 5; k++) begin
            @(negedge clk);
            check(pdm_clk == (k == 5), "R6 restart low phase", pdm_clk, k == 5);
        end
        check(sample_stb == 1, "R6 strobe after restart", sample_stb, 1);
    endtask

    task automatic t_disable();
        go_idle();
        div_val = 8'd1;
        qsel    = 3'b101;
        enable  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(pdm_clk == 1, "R7 running", pdm_clk, 1);
        enable = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!pdm_clk && !sample_stb && !cfg_err, "R7 quiet", pdm_clk, 0);
        end
        qsel = 3'b011;
        @(negedge clk);
        check(cfg_err == 0, "R7 no error while disabled", cfg_err, 0);
        qsel = 3'b000;
    endtask

    task automatic t_modes();
        for (int q = 0; q < 8; q++) begin
            for (int f = 0; f < 16; f++) begin
                @(negedge clk);
                qsel      = 3'(q);
                osr_field = 4'(f);
                #1;
                begin
                    bit legal = !(q == 2 || q == 3);
                    int eb = legal ? 4 * (16 - f) : 0;
                    int ed = legal ? 1024 / (2 * eb) : 0;
                    check(int'(bits_per_sample) == eb, "R8 bits_per_sample",
                          int'(bits_per_sample), eb);
                    check(int'(nominal_div) == ed, "R9 nominal_div",
                          int'(nominal_div), ed);
                end
            end
        end
        osr_field = 4'd0;
        qsel      = 3'b000;
    endtask

    task automatic t_div_drop();
        go_idle();
        div_val = 8'd20;
        qsel    = 3'b110;
        enable  = 1'b1;
        repeat (6) @(negedge clk);
        check(pdm_clk == 0, "R10 still low", pdm_clk, 0);
        div_val = 8'd2;
        @(negedge clk);
        check(pdm_clk == 1, "R10 early rise", pdm_clk, 1);
        check(sample_stb == 1, "R10 strobe", sample_stb, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_waveform(3, "R2 div3");
        t_waveform(7, "R2 div7");
        t_waveform(1, "R2 div1");
        t_waveform(0, "R4 div0");
        t_fault();
        t_disable();
        t_modes();
        t_div_drop();
        go_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule